// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This unit compares two single-precision IEEE-754 values and turns the result into six condition flags, laid out like the arithmetic flags of a general-purpose processor. Each comparison has one of four outcomes: greater, less, equal or unordered. That outcome is encoded on three of the flags. The other three flags are always cleared. A NaN operand of either kind makes the outcome unordered.

A mode bit chooses the NaN policy. In quiet mode only a signalling NaN raises the invalid exception. In signalling mode any NaN raises it. A denormal operand raises the denormal exception. Two mask inputs say whether each exception is masked. When an exception fires unmasked, the flag write is withheld and the flag register keeps its previous value.

Results are registered. They appear on the clock edge after the cycle in which the valid strobe is high. Only the low 32 bits of each operand port are examined.

Top module: `fcmp_flag_unit`

## Requirements
- R1: The flag vector `flagsOut` is laid out as bit 5 OF, bit 4 SF, bit 3 AF, bit 2 ZF, bit 1 PF, bit 0 CF. Bits 5 to 3 are always 0.
- R2: If either operand is a NaN (exponent all ones, mantissa nonzero), ZF, PF and CF are all written as 1 (unordered).
- R3: For ordered operands, with A compared against B: A greater than B writes ZF,PF,CF = 0,0,0; A less than B writes 0,0,1; A equal to B writes 1,0,0.
- R4: Positive zero and negative zero compare as equal.
- R5: Denormal operands (exponent zero, mantissa nonzero) are ordered by their true value against each other and against normals and zeros.
- R6: In quiet mode (`sigMode`=0), `excInvalid` is raised only when at least one operand is a signalling NaN, which is a NaN whose mantissa bit 22 is 0.
- R7: In signalling mode (`sigMode`=1), `excInvalid` is raised when either operand is a NaN of any kind.
- R8: `excDenorm` is raised when either operand is denormal.
- R9: If an exception is raised while its mask bit is 0, `flagsWe` stays low and `flagsOut` keeps its previous value. Masked exceptions do not block the write.
- R10: Bits of `opA` and `opB` above bit 31 have no effect on any output.
- R11: `flagsOut`, `flagsWe`, `excInvalid` and `excDenorm` reflect an operation on the first rising edge after `inValid` was high. `flagsWe`, `excInvalid` and `excDenorm` are low after any cycle in which `inValid` was low.
- R12: Reset (`rstN` low) clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| sigMode | input | 1 | 0 = quiet NaN policy, 1 = signalling NaN policy |
| opA | input | OPND_W | First operand; low 32 bits used |
| opB | input | OPND_W | Second operand; low 32 bits used |
| maskInvalid | input | 1 | 1 masks the invalid exception |
| maskDenorm | input | 1 | 1 masks the denormal exception |
| flagsOut | output | 6 | Registered flag vector (OF,SF,AF,ZF,PF,CF) |
| flagsWe | output | 1 | Flag write-enable pulse |
| excInvalid | output | 1 | Invalid exception indication |
| excDenorm | output | 1 | Denormal exception indication |

## Verification
The invalid and denormal exceptions can both fire on one operation, for example when one operand is a NaN and the other is denormal. The write suppression must then respond to either exception being unmasked, and must not require both. Directed cases pair a signalling NaN with a denormal under all four mask combinations. Random stimulus also mixes NaNs and denormals with random masks and modes. In each case both indications are checked against a bench model, and so are `flagsWe` and the held or updated flag value.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic writeFlags;
    logic raiseInvalid;
    logic raiseDenorm;
  } fcmpStrobe_t;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmpOutcome_t;

  localparam int FLAG_CF = 0;
  localparam int FLAG_PF = 1;
  localparam int FLAG_ZF = 2;
  localparam int FLAG_N  = 6;
endpackage

// File: rtl/fcmp_datapath.sv
`timescale 1ns/1ps
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [EXP_W+MAN_W:0]       fpA,
  input  logic [EXP_W+MAN_W:0]       fpB,
  input  fcmpStrobe_t                strobe,
  output logic [1:0]                 nanVec,
  output logic [1:0]                 snanVec,
  output logic [1:0]                 denVec,
  output logic [FLAG_N-1:0]          flagsOut,
  output logic                       flagsWe,
  output logic                       excInvalid,
  output logic                       excDenorm
);
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int MAG_W = FP_W - 1;

  logic [1:0]       zeroVec;
  logic [1:0]       sgn;
  logic [MAG_W-1:0] mag [2];

  for (genvar g = 0; g < 2; g++) begin : g_cls
    logic [FP_W-1:0]  v;
    logic [EXP_W-1:0] expF;
    logic [MAN_W-1:0] manF;
    assign v    = (g == 0) ? fpA : fpB;
    assign expF = v[FP_W-2:MAN_W];
    assign manF = v[MAN_W-1:0];
    assign sgn[g]     = v[FP_W-1];
    assign mag[g]     = v[MAG_W-1:0];
    assign nanVec[g]  = (&expF) & (|manF);
    assign snanVec[g] = (&expF) & (|manF) & ~manF[MAN_W-1];
    assign zeroVec[g] = ~(|expF) & ~(|manF);
    assign denVec[g]  = ~(|expF) & (|manF);
  end

  cmpOutcome_t outcome;
  always_comb begin
    if (|nanVec)                 outcome = CMP_UN;
    else if (&zeroVec)           outcome = CMP_EQ;
    else if (sgn[0] != sgn[1])   outcome = sgn[0] ? CMP_LT : CMP_GT;
    else if (mag[0] == mag[1])   outcome = CMP_EQ;
    else if ((mag[0] > mag[1]) ^ sgn[0]) outcome = CMP_GT;
    else                         outcome = CMP_LT;
  end

  logic [FLAG_N-1:0] nextFlags;
  always_comb begin
    nextFlags = '0;
    unique case (outcome)
      CMP_UN: begin
        nextFlags[FLAG_ZF] = 1'b1;
        nextFlags[FLAG_PF] = 1'b1;
        nextFlags[FLAG_CF] = 1'b1;
      end
      CMP_LT: nextFlags[FLAG_CF] = 1'b1;
      CMP_EQ: nextFlags[FLAG_ZF] = 1'b1;
      default: nextFlags = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsOut   <= '0;
      flagsWe    <= 1'b0;
      excInvalid <= 1'b0;
      excDenorm  <= 1'b0;
    end else begin
      flagsWe    <= strobe.writeFlags;
      excInvalid <= strobe.raiseInvalid;
      excDenorm  <= strobe.raiseDenorm;
      if (strobe.writeFlags) flagsOut <= nextFlags;
    end
  end
endmodule

// File: rtl/fcmp_control.sv
`timescale 1ns/1ps
module fcmp_control
  import fcmp_pkg::*;
(
  input  logic        inValid,
  input  logic        sigMode,
  input  logic        maskInvalid,
  input  logic        maskDenorm,
  input  logic [1:0]  nanVec,
  input  logic [1:0]  snanVec,
  input  logic [1:0]  denVec,
  output fcmpStrobe_t strobe
);
  logic invalidHit, denormHit, blocked;

  always_comb begin
    invalidHit = inValid & (sigMode ? (|nanVec) : (|snanVec));
    denormHit  = inValid & (|denVec);
    blocked    = (invalidHit & ~maskInvalid) | (denormHit & ~maskDenorm);
    strobe.raiseInvalid = invalidHit;
    strobe.raiseDenorm  = denormHit;
    strobe.writeFlags   = inValid & ~blocked;
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
`timescale 1ns/1ps
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int OPND_W = 128,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              sigMode,
  input  logic [OPND_W-1:0] opA,
  input  logic [OPND_W-1:0] opB,
  input  logic              maskInvalid,
  input  logic              maskDenorm,
  output logic [5:0]        flagsOut,
  output logic              flagsWe,
  output logic              excInvalid,
  output logic              excDenorm
);
  localparam int FP_W = 1 + EXP_W + MAN_W;

  logic [1:0]  nanVec, snanVec, denVec;
  fcmpStrobe_t strobe;

  if (OPND_W > FP_W) begin : g_high
    logic unusedHigh;
    assign unusedHigh = ^{opA[OPND_W-1:FP_W], opB[OPND_W-1:FP_W]};
  end

  fcmp_control u_ctrl (
    .inValid(inValid), .sigMode(sigMode),
    .maskInvalid(maskInvalid), .maskDenorm(maskDenorm),
    .nanVec(nanVec), .snanVec(snanVec), .denVec(denVec),
    .strobe(strobe)
  );

  fcmp_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .fpA(opA[FP_W-1:0]), .fpB(opB[FP_W-1:0]),
    .strobe(strobe),
    .nanVec(nanVec), .snanVec(snanVec), .denVec(denVec),
    .flagsOut(flagsOut), .flagsWe(flagsWe),
    .excInvalid(excInvalid), .excDenorm(excDenorm)
  );
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
`timescale 1ns/1ps
module fcmp_flag_unit_chk #(
  parameter int OPND_W = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              sigMode,
  input logic [OPND_W-1:0] opA,
  input logic [OPND_W-1:0] opB,
  input logic              maskInvalid,
  input logic              maskDenorm,
  input logic [5:0]        flagsOut,
  input logic              flagsWe,
  input logic              excInvalid,
  input logic              excDenorm
);
  logic anyNan, anySnan, bothZero, anyDen;
  assign anyNan   = (opA[30:23] == 8'hFF && opA[22:0] != 0) || (opB[30:23] == 8'hFF && opB[22:0] != 0);
  assign anySnan  = (opA[30:22] == 9'h1FE && opA[21:0] != 0) || (opB[30:22] == 9'h1FE && opB[21:0] != 0);
  assign bothZero = (opA[30:0] == 0) && (opB[30:0] == 0);
  assign anyDen   = (opA[30:23] == 0 && opA[22:0] != 0) || (opB[30:23] == 0 && opB[22:0] != 0);

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN) flagsOut[5:3] == 3'b000);
  // R2
  unordered_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && anyNan |=> !flagsWe || flagsOut[2:0] == 3'b111);
  // R4
  zero_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && bothZero |=> !flagsWe || flagsOut[2:0] == 3'b100);
  // R6
  quiet_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !sigMode && !anySnan |=> !excInvalid);
  // R7
  sig_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && sigMode && anyNan |=> excInvalid);
  // R8
  denorm_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && anyDen |=> excDenorm);
  // R9
  suppress_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && ((anyDen && !maskDenorm) || (anyNan && sigMode && !maskInvalid)) |=> !flagsWe);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flagsWe |-> $stable(flagsOut));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !flagsWe && !excInvalid && !excDenorm);
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk #(.OPND_W(OPND_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .sigMode(sigMode),
  .opA(opA), .opB(opB), .maskInvalid(maskInvalid), .maskDenorm(maskDenorm),
  .flagsOut(flagsOut), .flagsWe(flagsWe), .excInvalid(excInvalid), .excDenorm(excDenorm)
);

// File: tb/sim_fcmp_flag_unit.sv
`timescale 1ns/1ps
module sim_fcmp_flag_unit;
  localparam int OPND_W = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, sigMode = 1'b0, maskInvalid = 1'b1, maskDenorm = 1'b1;
  logic [OPND_W-1:0] opA = '0, opB = '0;
  logic [5:0] flagsOut;
  logic flagsWe, excInvalid, excDenorm;

  int checkCnt = 0;
  int failCnt = 0;
  logic [5:0] modelFlags = '0;

  always #10 clk = ~clk;

  fcmp_flag_unit #(.OPND_W(OPND_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sigMode(sigMode),
    .opA(opA), .opB(opB), .maskInvalid(maskInvalid), .maskDenorm(maskDenorm),
    .flagsOut(flagsOut), .flagsWe(flagsWe), .excInvalid(excInvalid), .excDenorm(excDenorm)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checkCnt++;
    if (act != expv) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic bit isNan(input logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction
  function automatic bit isSnan(input logic [31:0] v);
    return isNan(v) && !v[22];
  endfunction
  function automatic bit isDen(input logic [31:0] v);
    return v[30:23] == 0 && v[22:0] != 0;
  endfunction
  // signed ordering key: zeros of both signs map to 0
  function automatic longint orderKey(input logic [31:0] v);
    longint m;
    m = longint'(v[30:0]);
    return v[31] ? -m : m;
  endfunction
  function automatic logic [5:0] refFlags(input logic [31:0] a, input logic [31:0] b);
    longint ka, kb;
    if (isNan(a) || isNan(b)) return 6'b000111;
    ka = orderKey(a);
    kb = orderKey(b);
    if (ka > kb) return 6'b000000;
    if (ka < kb) return 6'b000001;
    return 6'b000100;
  endfunction

  function automatic logic [31:0] pickOperand();
    logic [31:0] r;
    r = $urandom;
    case ($urandom_range(0, 8))
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return {r[31], 8'hFF, 1'b1, r[21:0]};
      3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      4: return {r[31], 8'h00, r[22:1], 1'b1};
      5: return {r[31], 8'hFF, 23'h0};
      6: return {r[31], 8'h7F, 20'h0, r[2:0]};
      default: return r;
    endcase
  endfunction

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic [OPND_W-33:0] hiA,
                       input logic [OPND_W-33:0] hiB, input bit mode, input bit mi, input bit md,
                       input string tag);
    bit eInv, eDen, eWe;
    logic [5:0] eFlags;
    string ft;
    @(negedge clk);
    opA = {hiA, a};
    opB = {hiB, b};
    sigMode = mode;
    maskInvalid = mi;
    maskDenorm = md;
    inValid = 1'b1;
    eInv = mode ? (isNan(a) || isNan(b)) : (isSnan(a) || isSnan(b));
    eDen = isDen(a) || isDen(b);
    eWe = !((eInv && !mi) || (eDen && !md));
    eFlags = refFlags(a, b);
    if (eWe) modelFlags = eFlags;
    if (isNan(a) || isNan(b)) ft = "R2 unordered";
    else if (a[30:0] == 0 && b[30:0] == 0) ft = "R4 zero equality";
    else if (isDen(a) || isDen(b)) ft = "R5 denormal order";
    else ft = "R3 ordered outcome";
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk({ft, " (R11 timing) ", tag}, int'(flagsOut), int'(modelFlags));
    chk({"R1 upper flags ", tag}, int'(flagsOut[5:3]), 0);
    chk({"R9 write enable ", tag}, int'(flagsWe), int'(eWe));
    chk({mode ? "R7 invalid sig " : "R6 invalid quiet ", tag}, int'(excInvalid), int'(eInv));
    chk({"R8 denormal ", tag}, int'(excDenorm), int'(eDen));
    @(posedge clk);
    @(negedge clk);
    chk({"R11 idle pulses ", tag}, int'({flagsWe, excInvalid, excDenorm}), 0);
    chk({"R9 flags held ", tag}, int'(flagsOut), int'(modelFlags));
  endtask

  initial begin
    #(20 * 150000);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    chk("R12 reset flags", int'(flagsOut), 0);
    chk("R12 reset pulses", int'({flagsWe, excInvalid, excDenorm}), 0);
    rstN = 1'b1;

    // directed corner cases
    runOp(32'h3F80_0000, 32'h4000_0000, '0, '0, 0, 1, 1, "lt 1<2");
    runOp(32'h4000_0000, 32'h3F80_0000, '0, '0, 0, 1, 1, "gt 2>1");
    runOp(32'hC000_0000, 32'hBF80_0000, '0, '0, 0, 1, 1, "lt -2<-1");
    runOp(32'h3F80_0000, 32'h3F80_0000, '0, '0, 0, 1, 1, "eq");
    runOp(32'h8000_0000, 32'h0000_0000, '0, '0, 0, 1, 1, "R4 -0==+0");
    runOp(32'h0000_0001, 32'h0000_0002, '0, '0, 0, 1, 1, "R5 den<den");
    runOp(32'h8000_0001, 32'h0000_0000, '0, '0, 0, 1, 1, "R5 -den<+0");
    runOp(32'h007F_FFFF, 32'h0080_0000, '0, '0, 0, 1, 1, "R5 den<min normal");
    runOp(32'h7FC0_0000, 32'h3F80_0000, '0, '0, 0, 1, 1, "R2/R6 qnan quiet");
    runOp(32'h7FC0_0000, 32'h3F80_0000, '0, '0, 1, 1, 1, "R7 qnan sig");
    runOp(32'h3F80_0000, 32'h7F80_0001, '0, '0, 0, 1, 1, "R6 snan quiet");
    runOp(32'h3F80_0000, 32'h3F80_0000, '0, '0, 0, 1, 1, "eq before suppression");
    runOp(32'h7F80_0001, 32'h3F80_0000, '0, '0, 0, 0, 1, "R9 unmasked invalid");
    runOp(32'h0000_0005, 32'h4000_0000, '0, '0, 0, 1, 0, "R9 unmasked denormal");
    for (int m = 0; m < 4; m++)
      runOp(32'hFFA0_0000, 32'h0000_0010, '0, '0, 0, m[0], m[1], "invalid+denormal");
    runOp(32'h4000_0000, 32'h3F80_0000, {96{1'b1}}, '0, 0, 1, 1, "R10 high bits gt");
    runOp(32'h3F80_0000, 32'h3F80_0000, 96'hDEAD_BEEF, {3{32'h7FC0_0001}}, 1, 0, 0, "R10 high bits eq");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [95:0] hA, hB;
      hA = {$urandom, $urandom, $urandom};
      hB = {$urandom, $urandom, $urandom};
      runOp(pickOperand(), pickOperand(), hA, hB, 1'($urandom), 1'($urandom), 1'($urandom), "random");
    end

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule